// File: doc/BRIEF.md
# ADC Channel Conversion Sequencer

This block chooses the channel the analog converter samples next and paces the conversions of a sequence. An eight-channel enable set is changed through separate set and clear strobes and is visible as a status vector. A sequence walks either the enabled channels in ascending index, or a programmed list of seven 4-bit slots in which one channel may appear more than once.

A sequence begins on a software start strobe, on a rising edge of one selected hardware trigger line, or continuously in free-run mode. For each step the block emits a one-cycle convert pulse with a channel number. It waits for the converter's done strobe with its data, stores the result per channel and moves to the next step. Per-channel end-of-conversion flags, per-channel overrun flags and a general overrun flag are kept for the consumer of the results.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Each bit set in `ch_en_set` enables that channel at the next clock, and each bit set in `ch_en_clr` disables it. Zero bits leave a channel unchanged. When both strobes carry 1 for the same bit, the channel ends disabled. `ch_status` shows the enable set.
- R2: With `user_order` at 0, a sequence converts every enabled channel once, lowest index first.
- R3: With `user_order` at 1, step p (p = 0..6) uses the channel number in `slot_list[4p+3:4p]`, but only when enable bit p is set. Bit 7 of the enable set plays no part in this mode. The same channel may appear in several slots, and the sequence ends after the last usable slot.
- R4: In user order, a slot holding a value of 8 or more is skipped.
- R5: `sw_start` always requests a sequence. A 0-to-1 change of `hw_trig[trig_sel]` requests one only while `trig_en` is 1, and the other trigger lines are never used. `conv_start` rises in the cycle after the request. A request with no usable step starts nothing.
- R6: With `free_run` at 1, the block starts a sequence without any request. After a sequence ends it starts the next one, with `conv_start` high two cycles after the final done.
- R7: `conv_start` is a one-cycle pulse with `conv_ch` valid. The next step's pulse follows in the cycle after an accepted `conv_done`. `conv_done` is ignored when no step is outstanding. `seq_busy` is low in the cycle after the last step's done.
- R8: An accepted done stores `conv_data` for `conv_ch` and sets `eoc_flags[conv_ch]`. A `rd_strobe` returns that channel's result on `rd_data` (combinationally from `rd_ch`) and clears the flag.
- R9: A done on a channel whose end-of-conversion flag is still set sets `ovr_flags` for that channel and sets `gen_ovr`. `stat_rd` clears all overrun flags, but a new overrun in the same cycle wins.
- R10: A start request that arrives while a sequence is running is ignored and is not held for later.
- R11: `soft_rst` clears the enable set, the step position, busy and all flags at the next clock. A done that follows it is ignored.
- R12: When a done and a read of the same channel fall in one cycle, the read returns the old result, the end-of-conversion flag stays set and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of enables, sequence state and flags |
| ch_en_set | input | 8 | Per-channel enable strobes |
| ch_en_clr | input | 8 | Per-channel disable strobes |
| ch_status | output | 8 | Current enable set |
| user_order | input | 1 | 0: ascending index order, 1: slot list order |
| slot_list | input | 28 | Seven 4-bit slots, slot p at bits 4p+3:4p |
| free_run | input | 1 | Run sequences back to back without requests |
| trig_en | input | 1 | Allow the selected hardware trigger |
| trig_sel | input | 3 | Index of the hardware trigger line |
| hw_trig | input | 8 | Hardware trigger lines |
| sw_start | input | 1 | Software start strobe |
| conv_start | output | 1 | One-cycle convert pulse |
| conv_ch | output | 4 | Channel to convert |
| conv_done | input | 1 | Converter finished, data valid |
| conv_data | input | 12 | Converted result |
| rd_strobe | input | 1 | Consume the result of `rd_ch` |
| rd_ch | input | 3 | Channel whose result is read |
| rd_data | output | 12 | Stored result of `rd_ch` |
| eoc_flags | output | 8 | Per-channel unread-result flags |
| ovr_flags | output | 8 | Per-channel overrun flags |
| stat_rd | input | 1 | Status read, clears overrun flags |
| gen_ovr | output | 1 | General overrun flag |
| seq_busy | output | 1 | A sequence is in progress |

## Verification
Two collisions are forced. In the first, the converter's done for a channel arrives in the same cycle as the consumer's read of that channel's earlier result. This is set up by holding an unread result and then driving `conv_done` and `rd_strobe` on the same negative edge. The check expects the old data on `rd_data`, the end-of-conversion flag still set and no overrun. In the second, a done that creates an overrun coincides with a status read, and the overrun flags must stay set. The random phase covers enable sets, slot lists with repeats and out-of-range slots, and converter latencies, against an order computed by a bench function.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int DEF_NCH    = 8;
    localparam int DEF_NSLOT  = 7;
    localparam int DEF_SLOT_W = 4;
    localparam int DEF_DATA_W = 12;
    localparam int DEF_NTRIG  = 8;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/seq_en_reg.sv
module seq_en_reg #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           soft_rst,
    input  logic [NCH-1:0] set_i,
    input  logic [NCH-1:0] clr_i,
    output logic [NCH-1:0] en_o
);
    typedef struct packed {
        logic [NCH-1:0] en;
    } en_st_t;

    en_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (soft_rst) st_d.en = '0;
        else          st_d.en = (st_q.en | set_i) & ~clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o = st_q.en;

    // R1
    en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_i) |=> ((st_q.en & $past(clr_i)) == '0));
    // R1
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(set_i & ~clr_i)) && !soft_rst) |=>
            ((st_q.en & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));
endmodule

// File: rtl/seq_step_pick.sv
module seq_step_pick #(
    parameter int NCH    = 8,
    parameter int NSLOT  = 7,
    parameter int SLOT_W = 4,
    parameter int PW     = 4
) (
    input  logic                    user_mode,
    input  logic [NCH-1:0]          en,
    input  logic [NSLOT*SLOT_W-1:0] slots,
    input  logic [PW-1:0]           from_pos,
    output logic                    found,
    output logic [PW-1:0]           hit_pos,
    output logic [SLOT_W-1:0]       hit_ch
);
    import adc_seq_pkg::*;
    localparam int L = imax(NCH, NSLOT);

    logic [L-1:0]             cand;
    logic [L-1:0][SLOT_W-1:0] ch_of;

    for (genvar g = 0; g < L; g++) begin : g_pos
        logic asc_ok, usr_ok;
        logic [SLOT_W-1:0] usr_ch;
        if (g < NCH) begin : g_asc
            assign asc_ok = en[g];
        end else begin : g_noasc
            assign asc_ok = 1'b0;
        end
        if ((g < NSLOT) && (g < NCH)) begin : g_usr
            assign usr_ch = slots[g*SLOT_W +: SLOT_W];
            assign usr_ok = en[g] && (int'(usr_ch) < NCH);
        end else begin : g_nousr
            assign usr_ch = '0;
            assign usr_ok = 1'b0;
        end
        assign cand[g]  = user_mode ? usr_ok : asc_ok;
        assign ch_of[g] = user_mode ? usr_ch : SLOT_W'(g);
    end

    // lowest candidate at or above from_pos
    always_comb begin
        found   = 1'b0;
        hit_pos = '0;
        hit_ch  = '0;
        for (int i = L - 1; i >= 0; i--) begin
            if (cand[i] && (PW'(i) >= from_pos)) begin
                found   = 1'b1;
                hit_pos = PW'(i);
                hit_ch  = ch_of[i];
            end
        end
    end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm #(
    parameter int NTRIG = 8,
    parameter int PW    = 4,
    parameter int CH_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     soft_rst,
    input  logic                     free_run,
    input  logic                     sw_start,
    input  logic                     trig_en,
    input  logic [$clog2(NTRIG)-1:0] trig_sel,
    input  logic [NTRIG-1:0]         hw_trig,
    input  logic                     conv_done,
    input  logic                     found,
    input  logic [PW-1:0]            hit_pos,
    input  logic [CH_W-1:0]          hit_ch,
    output logic [PW-1:0]            pick_from,
    output logic                     conv_start,
    output logic [CH_W-1:0]          conv_ch,
    output logic                     busy,
    output logic                     wr_en
);
    typedef struct packed {
        logic            busy;
        logic            waiting;
        logic            start;
        logic [PW-1:0]   pos;
        logic [CH_W-1:0] ch;
        logic            trig_prev;
    } fsm_st_t;

    fsm_st_t st_d, st_q;
    logic trig_now, trig_rise, start_req, done_ok;

    assign trig_now  = hw_trig[trig_sel];
    assign trig_rise = trig_en && trig_now && !st_q.trig_prev;
    assign start_req = free_run || sw_start || trig_rise;
    assign done_ok   = st_q.waiting && conv_done;
    assign pick_from = st_q.busy ? st_q.pos : '0;

    always_comb begin
        st_d           = st_q;
        st_d.start     = 1'b0;
        st_d.trig_prev = trig_now;
        if (soft_rst) begin
            st_d           = '0;
            st_d.trig_prev = trig_now;
        end else if (!st_q.busy) begin
            if (start_req && found) begin
                st_d.busy    = 1'b1;
                st_d.waiting = 1'b1;
                st_d.start   = 1'b1;
                st_d.ch      = hit_ch;
                st_d.pos     = PW'(hit_pos + 1'b1);
            end
        end else if (done_ok) begin
            if (found) begin
                st_d.start = 1'b1;
                st_d.ch    = hit_ch;
                st_d.pos   = PW'(hit_pos + 1'b1);
            end else begin
                st_d.busy    = 1'b0;
                st_d.waiting = 1'b0;
                st_d.pos     = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign conv_start = st_q.start;
    assign conv_ch    = st_q.ch;
    assign busy       = st_q.busy;
    assign wr_en      = done_ok && !soft_rst;

    // R7
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && !(conv_done && st_q.waiting)) |=> !conv_start);
    // R10
    no_step_wo_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !(st_q.waiting && conv_done)) |=> !conv_start);
    // R11
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!busy && st_q.pos == '0 && !conv_start));
endmodule

// File: rtl/seq_result_store.sv
module seq_result_store #(
    parameter int NCH = 8,
    parameter int DW  = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   soft_rst,
    input  logic                   wr_en,
    input  logic [$clog2(NCH)-1:0] wr_ch,
    input  logic [DW-1:0]          wr_data,
    input  logic                   rd_strobe,
    input  logic [$clog2(NCH)-1:0] rd_ch,
    input  logic                   stat_rd,
    output logic [DW-1:0]          rd_data,
    output logic [NCH-1:0]         eoc,
    output logic [NCH-1:0]         ovr,
    output logic                   gen
);
    localparam int IW = $clog2(NCH);

    typedef struct packed {
        logic [NCH-1:0][DW-1:0] data;
        logic [NCH-1:0]         eoc;
        logic [NCH-1:0]         ovr;
        logic                   gen;
    } res_st_t;

    res_st_t st_d, st_q;

    always_comb begin
        logic [NCH-1:0] new_ovr;
        st_d    = st_q;
        new_ovr = '0;
        for (int c = 0; c < NCH; c++) begin
            logic wr_hit, rd_hit;
            wr_hit = wr_en && (wr_ch == IW'(c));
            rd_hit = rd_strobe && (rd_ch == IW'(c));
            new_ovr[c] = wr_hit && st_q.eoc[c] && !rd_hit;
            if (wr_hit) begin
                st_d.data[c] = wr_data;
                st_d.eoc[c]  = 1'b1;
            end else if (rd_hit) begin
                st_d.eoc[c]  = 1'b0;
            end
        end
        st_d.ovr = (stat_rd ? '0 : st_q.ovr) | new_ovr;
        st_d.gen = (stat_rd ? 1'b0 : st_q.gen) | (|new_ovr);
        if (soft_rst) begin
            st_d.eoc = '0;
            st_d.ovr = '0;
            st_d.gen = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.data[rd_ch];
    assign eoc     = st_q.eoc;
    assign ovr     = st_q.ovr;
    assign gen     = st_q.gen;

    // R8
    eoc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !soft_rst) |=> eoc[$past(wr_ch)]);
    // R9
    ovr_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !soft_rst && eoc[wr_ch] && !(rd_strobe && rd_ch == wr_ch))
            |=> (gen && ovr[$past(wr_ch)]));
    // R12
    same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_strobe && rd_ch == wr_ch && !ovr[wr_ch])
            |=> (!ovr[$past(wr_ch)] && eoc[$past(wr_ch)]));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
    parameter int NCH    = adc_seq_pkg::DEF_NCH,
    parameter int NSLOT  = adc_seq_pkg::DEF_NSLOT,
    parameter int SLOT_W = adc_seq_pkg::DEF_SLOT_W,
    parameter int DW     = adc_seq_pkg::DEF_DATA_W,
    parameter int NTRIG  = adc_seq_pkg::DEF_NTRIG
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     soft_rst,
    input  logic [NCH-1:0]           ch_en_set,
    input  logic [NCH-1:0]           ch_en_clr,
    output logic [NCH-1:0]           ch_status,
    input  logic                     user_order,
    input  logic [NSLOT*SLOT_W-1:0]  slot_list,
    input  logic                     free_run,
    input  logic                     trig_en,
    input  logic [$clog2(NTRIG)-1:0] trig_sel,
    input  logic [NTRIG-1:0]         hw_trig,
    input  logic                     sw_start,
    output logic                     conv_start,
    output logic [SLOT_W-1:0]        conv_ch,
    input  logic                     conv_done,
    input  logic [DW-1:0]            conv_data,
    input  logic                     rd_strobe,
    input  logic [$clog2(NCH)-1:0]   rd_ch,
    output logic [DW-1:0]            rd_data,
    output logic [NCH-1:0]           eoc_flags,
    output logic [NCH-1:0]           ovr_flags,
    input  logic                     stat_rd,
    output logic                     gen_ovr,
    output logic                     seq_busy
);
    import adc_seq_pkg::*;
    localparam int L  = imax(NCH, NSLOT);
    localparam int PW = $clog2(L + 1);
    localparam int IW = $clog2(NCH);

    logic [NCH-1:0]    en;
    logic [PW-1:0]     pick_from, hit_pos;
    logic [SLOT_W-1:0] hit_ch;
    logic              found, wr_en;

    seq_en_reg #(.NCH(NCH)) u_en (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .set_i(ch_en_set), .clr_i(ch_en_clr), .en_o(en)
    );

    seq_step_pick #(.NCH(NCH), .NSLOT(NSLOT), .SLOT_W(SLOT_W), .PW(PW)) u_pick (
        .user_mode(user_order), .en(en), .slots(slot_list),
        .from_pos(pick_from), .found(found), .hit_pos(hit_pos), .hit_ch(hit_ch)
    );

    seq_fsm #(.NTRIG(NTRIG), .PW(PW), .CH_W(SLOT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .free_run(free_run),
        .sw_start(sw_start), .trig_en(trig_en), .trig_sel(trig_sel),
        .hw_trig(hw_trig), .conv_done(conv_done), .found(found),
        .hit_pos(hit_pos), .hit_ch(hit_ch), .pick_from(pick_from),
        .conv_start(conv_start), .conv_ch(conv_ch), .busy(seq_busy),
        .wr_en(wr_en)
    );

    seq_result_store #(.NCH(NCH), .DW(DW)) u_res (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .wr_en(wr_en), .wr_ch(conv_ch[IW-1:0]), .wr_data(conv_data),
        .rd_strobe(rd_strobe), .rd_ch(rd_ch), .stat_rd(stat_rd),
        .rd_data(rd_data), .eoc(eoc_flags), .ovr(ovr_flags), .gen(gen_ovr)
    );

    assign ch_status = en;
endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst_n = 0, soft_rst = 0;
    logic [7:0]  ch_en_set = 0, ch_en_clr = 0, ch_status;
    logic        user_order = 0, free_run = 0, trig_en = 0, sw_start = 0;
    logic [27:0] slot_list = 0;
    logic [2:0]  trig_sel = 0, rd_ch = 0;
    logic [7:0]  hw_trig = 0, eoc_flags, ovr_flags;
    logic        conv_start, conv_done = 0, rd_strobe = 0, stat_rd = 0;
    logic        gen_ovr, seq_busy;
    logic [3:0]  conv_ch;
    logic [11:0] conv_data = 0, rd_data;

    adc_seq_ctrl dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0, n_fail = 0;
    bit done_flag = 0;
    int exp_seq [0:7];
    int exp_n;
    logic [11:0] ref_data [0:7];
    logic [7:0]  ref_eoc = 0, ref_ovr = 0;
    logic        ref_gen = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void build_order(input bit usr, input logic [7:0] en, input logic [27:0] sl);
        exp_n = 0;
        if (!usr) begin
            for (int c = 0; c < 8; c++) if (en[c]) begin exp_seq[exp_n] = c; exp_n++; end
        end else begin
            for (int s = 0; s < 7; s++) begin
                int v;
                v = int'(sl[s*4 +: 4]);
                if (en[s] && v < 8) begin exp_seq[exp_n] = v; exp_n++; end
            end
        end
    endfunction

    task automatic prog_en(input logic [7:0] v);
        ch_en_clr = 8'hFF; @(negedge clk);
        ch_en_clr = 0; ch_en_set = v; @(negedge clk);
        ch_en_set = 0;
        chk(ch_status == v, "R1 status", ch_status, v);
    endtask

    task automatic model_write(input int c, input logic [11:0] d, input bit rd_same);
        if (ref_eoc[c] && !rd_same) begin ref_ovr[c] = 1'b1; ref_gen = 1'b1; end
        ref_eoc[c] = 1'b1;
        ref_data[c] = d;
    endtask

    task automatic do_seq(input bit fire);
        if (fire) begin sw_start = 1; @(negedge clk); sw_start = 0; end
        for (int k = 0; k < exp_n; k++) begin
            int w;
            int d;
            w = 0;
            while (!conv_start && w < 16) begin @(negedge clk); w++; end
            chk(conv_start === 1'b1, "R7 step pulse", conv_start, 1);
            chk(int'(conv_ch) == exp_seq[k], user_order ? "R3 slot order" : "R2 ascending order",
                conv_ch, exp_seq[k]);
            d = $urandom % 3;
            repeat (d) @(negedge clk);
            conv_done = 1; conv_data = 12'($urandom);
            model_write(int'(conv_ch), conv_data, 1'b0);
            @(negedge clk);
            conv_done = 0;
        end
        if (exp_n == 0) begin
            for (int i = 0; i < 4; i++) begin
                chk(conv_start == 0, "R5 empty set no start", conv_start, 0);
                @(negedge clk);
            end
        end
        chk(seq_busy == 0, "R7 busy low after last", seq_busy, 0);
    endtask

    task automatic check_flags(input string tag);
        chk(eoc_flags == ref_eoc, {tag, " R8 eoc"}, eoc_flags, ref_eoc);
        chk(ovr_flags == ref_ovr, {tag, " R9 ovr"}, ovr_flags, ref_ovr);
        chk(gen_ovr == ref_gen, {tag, " R9 gen"}, gen_ovr, ref_gen);
    endtask

    task automatic read_ch(input int c);
        rd_strobe = 1; rd_ch = 3'(c); #1;
        chk(rd_data == ref_data[c], "R8 read data", rd_data, ref_data[c]);
        @(negedge clk);
        rd_strobe = 0;
        ref_eoc[c] = 1'b0;
    endtask

    task automatic read_status();
        stat_rd = 1; @(negedge clk); stat_rd = 0;
        ref_ovr = 0; ref_gen = 0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 8; i++) ref_data[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state
        chk(ch_status == 0, "R11 reset enables", ch_status, 0);
        chk(conv_start == 0 && seq_busy == 0, "R7 reset idle", {conv_start, seq_busy}, 0);
        check_flags("reset");

        // R1 same-bit set and clear
        ch_en_set = 8'h0F; @(negedge clk); ch_en_set = 0;
        ch_en_set = 8'hF0; ch_en_clr = 8'h11; @(negedge clk);
        ch_en_set = 0; ch_en_clr = 0;
        chk(ch_status == 8'hEE, "R1 clear wins", ch_status, 8'hEE);

        // R2 directed ascending
        prog_en(8'hA5); user_order = 0;
        build_order(0, 8'hA5, slot_list); do_seq(1);
        check_flags("asc");
        for (int c = 0; c < 8; c++) if (ref_eoc[c]) read_ch(c);

        // R3 repeats and R4 out-of-range slot; bit 7 ignored
        user_order = 1;
        slot_list = {4'd2, 4'd9, 4'd5, 4'd2, 4'd2, 4'd0, 4'd7};
        prog_en(8'hFF);
        build_order(1, 8'hFF, slot_list);
        chk(exp_n == 6, "R4 skip count model", exp_n, 6);
        do_seq(1);
        check_flags("R3 usr");
        read_status();
        check_flags("R9 after status read");
        for (int c = 0; c < 8; c++) if (ref_eoc[c]) read_ch(c);

        // R5 hardware triggers
        user_order = 0; prog_en(8'h11); trig_sel = 3'd5; trig_en = 0;
        hw_trig[5] = 1; @(negedge clk); hw_trig = 0;
        for (int i = 0; i < 4; i++) begin
            chk(conv_start == 0, "R5 trigger disabled", conv_start, 0); @(negedge clk);
        end
        trig_en = 1;
        hw_trig[2] = 1; @(negedge clk); hw_trig = 0;
        for (int i = 0; i < 4; i++) begin
            chk(conv_start == 0, "R5 unselected line", conv_start, 0); @(negedge clk);
        end
        hw_trig[5] = 1; @(negedge clk);
        chk(conv_start == 1, "R5 selected edge", conv_start, 1);
        build_order(0, 8'h11, slot_list); do_seq(0);
        for (int i = 0; i < 4; i++) begin
            chk(conv_start == 0, "R5 held level no retrigger", conv_start, 0); @(negedge clk);
        end
        hw_trig = 0; trig_en = 0;
        for (int c = 0; c < 8; c++) if (ref_eoc[c]) read_ch(c);

        // R6 free run
        prog_en(8'h06); build_order(0, 8'h06, slot_list);
        free_run = 1; @(negedge clk);
        do_seq(0);
        @(negedge clk);
        chk(conv_start == 1 && conv_ch == 1, "R6 restart after end", {conv_start, conv_ch}, 5'h11);
        free_run = 0;
        do_seq(0);
        check_flags("R6 free run");
        read_status();
        for (int c = 0; c < 8; c++) if (ref_eoc[c]) read_ch(c);

        // R10 start while busy ignored
        prog_en(8'h02); build_order(0, 8'h02, slot_list);
        sw_start = 1; @(negedge clk);
        chk(conv_start == 1, "R10 first start", conv_start, 1);
        @(negedge clk); @(negedge clk);
        sw_start = 0; conv_done = 1; conv_data = 12'h3C5;
        model_write(1, 12'h3C5, 1'b0);
        @(negedge clk); conv_done = 0;
        chk(seq_busy == 0, "R10 busy low", seq_busy, 0);
        for (int i = 0; i < 4; i++) begin
            chk(conv_start == 0, "R10 not queued", conv_start, 0); @(negedge clk);
        end

        // R7 done while idle ignored
        conv_done = 1; conv_data = 12'hFFF; @(negedge clk); conv_done = 0;
        check_flags("R7 stray done");

        // R12 done and read of same channel in one cycle (ch1 holds unread result)
        sw_start = 1; @(negedge clk); sw_start = 0;
        chk(conv_start == 1 && conv_ch == 1, "R12 step", {conv_start, conv_ch}, 5'h11);
        conv_done = 1; conv_data = 12'h0A7; rd_strobe = 1; rd_ch = 3'd1; #1;
        chk(rd_data == 12'h3C5, "R12 old data returned", rd_data, 12'h3C5);
        model_write(1, 12'h0A7, 1'b1);
        @(negedge clk); conv_done = 0; rd_strobe = 0;
        check_flags("R12 collision");

        // R9 overrun coincides with status read
        sw_start = 1; @(negedge clk); sw_start = 0;
        conv_done = 1; conv_data = 12'h111; stat_rd = 1;
        ref_ovr = 0; ref_gen = 0;
        model_write(1, 12'h111, 1'b0);
        @(negedge clk); conv_done = 0; stat_rd = 0;
        check_flags("R9 set beats clear");

        // random phase
        for (int it = 0; it < 14; it++) begin
            logic [7:0] en_r;
            en_r = 8'($urandom);
            user_order = 1'($urandom);
            slot_list = 28'($urandom);
            prog_en(en_r);
            build_order(user_order, en_r, slot_list);
            do_seq(1);
            check_flags("rand");
            if ($urandom % 2) read_status();
            for (int c = 0; c < 8; c++) if (ref_eoc[c] && ($urandom % 2)) read_ch(c);
            check_flags("rand after reads");
        end

        // R11 soft reset mid sequence
        user_order = 0; prog_en(8'hFF);
        sw_start = 1; @(negedge clk); sw_start = 0;
        chk(conv_start == 1, "R11 started", conv_start, 1);
        soft_rst = 1; @(negedge clk); soft_rst = 0;
        ref_eoc = 0; ref_ovr = 0; ref_gen = 0;
        chk(ch_status == 0 && seq_busy == 0, "R11 cleared", {ch_status, seq_busy}, 0);
        check_flags("R11");
        conv_done = 1; @(negedge clk); conv_done = 0;
        check_flags("R11 done after reset");
        chk(conv_start == 0, "R11 no further step", conv_start, 0);

        finish_run();
    end
endmodule